// File: doc/BRIEF.md
# Fractional multiply-accumulate data unit

This block is the arithmetic core of a 24-bit fixed-point signal processor. It owns four 24-bit operand registers and two 56-bit accumulators, and every source operand it uses comes from one of those registers or accumulators. Each accumulator is an 8-bit guard (extension) field on top of a 48-bit body, so that sums of many fractional products can grow past ±1.0 without wrapping. Operands are signed two's-complement fractions. A 24×24 product is doubled (shifted left one place) to align the binary point and is sign-extended through the guard bits before it is combined with an accumulator.

In a single clock cycle, with no pipelining, the unit performs one operation selected by a 4-bit code: a plain or negated multiply, a multiply-accumulate that adds or subtracts the product (optionally followed in the same cycle by convergent rounding), a standalone rounding, an add or subtract of a 24-bit, 48-bit or 56-bit source, or a bitwise AND/OR/XOR on the middle word. The result always goes to the accumulator named by the destination select and is visible on the accumulator read ports after the clock edge that accepted the operation. Operand registers are written through a separate load port, one register per cycle.

The block has no multi-cycle sequencing: an accepted operation completes at the edge that takes it, so there is no state machine beyond the register contents themselves.

Top module: `frac_mac_unit`

## Requirements
- R1: After reset both accumulators and all four operand registers hold zero.
- R2: With ld_en high, ld_data is written at the clock edge into operand register ld_sel (0..3); the other operand registers keep their values.
- R3: Code 0x0 writes the doubled signed product of registers op_src_a and op_src_b, sign-extended to 56 bits; code 0x1 writes its negation. The product of -1.0 by -1.0 (0x800000 × 0x800000) gives 0x00800000000000 with no wrap.
- R4: Code 0x2 adds the doubled product to the destination accumulator and code 0x3 subtracts it, modulo 2^56, so results that pass ±1.0 carry into the guard bits.
- R5: Convergent rounding adds 2^23 and clears bits 23..0; when bits 23..0 were exactly 0x800000, bit 24 of the result is forced to zero (round half to even). Code 0x6 rounds the destination; codes 0x4 and 0x5 round the result of the add-product and subtract-product accumulation in the same cycle.
- R6: Codes 0x7 and 0x8 add and subtract register op_src_a, sign-extended and placed at bits 47..24, to and from the destination.
- R7: Code 0x9 adds the 48-bit register pair selected by op_src_a bit 1 (0: {reg1,reg0}, 1: {reg3,reg2}, high word first), sign-extended; codes 0xA and 0xB add and subtract the other accumulator (56-bit source) to and from the destination.
- R8: Codes 0xC, 0xD and 0xE replace bits 47..24 of the destination with their AND, OR and XOR with register op_src_a; bits 55..48 and 23..0 are unchanged. Code 0xF leaves the destination unchanged.
- R9: An operation is accepted when op_valid is high, and its result appears at the edge that accepts it. op_dst selects the destination (0: accumulator 0, 1: accumulator 1); the other accumulator is not changed. With op_valid low, neither accumulator changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Operand register write strobe |
| ld_sel | input | 2 | Operand register to write |
| ld_data | input | 24 | Operand value to write |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| op_src_a | input | 2 | First operand register select |
| op_src_b | input | 2 | Second operand register select |
| op_dst | input | 1 | Destination accumulator select |
| acc0_q | output | 56 | Accumulator 0 contents |
| acc1_q | output | 56 | Accumulator 1 contents |

## Verification
The bench sweeps every operation code into both accumulators over a grid of operand values that includes the most negative value, zero, ±LSB and full scale, and compares against a 64-bit integer model after every operation. It targets the -1.0 × -1.0 product, which a design that drops the guard bits would wrap to -1.0, and repeated accumulation of full-scale products, where a 48-bit accumulator would lose the carry into the guard field. Rounding ties with an even and with an odd upper word are checked directly: rounding that always rounds half up would return a value one LSB too high in the even case. The bench also checks that logic operations leave the guard and low words alone, and that the accumulator that is not the destination, and both accumulators while op_valid is low, stay unchanged.

// File: rtl/fmac_pkg.sv
package fmac_pkg;

    typedef enum logic [3:0] {
        OP_MPY   = 4'h0,
        OP_MPYN  = 4'h1,
        OP_MAC   = 4'h2,
        OP_MACN  = 4'h3,
        OP_MACR  = 4'h4,
        OP_MACNR = 4'h5,
        OP_RND   = 4'h6,
        OP_ADDX  = 4'h7,
        OP_SUBX  = 4'h8,
        OP_ADDL  = 4'h9,
        OP_ADDA  = 4'hA,
        OP_SUBA  = 4'hB,
        OP_AND   = 4'hC,
        OP_OR    = 4'hD,
        OP_XOR   = 4'hE,
        OP_NOP   = 4'hF
    } op_e;

    function automatic logic is_logic_op(input op_e o);
        return (o == OP_AND) || (o == OP_OR) || (o == OP_XOR);
    endfunction

    function automatic logic is_round_op(input op_e o);
        return (o == OP_MACR) || (o == OP_MACNR) || (o == OP_RND);
    endfunction

endpackage

// File: rtl/fmac_operand_regs.sv
module fmac_operand_regs #(
    parameter  int DW   = 24,
    parameter  int NREG = 4,
    localparam int SW   = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [SW-1:0] ld_sel,
    input  logic [DW-1:0] ld_data,
    output logic [DW-1:0] regs_q [NREG]
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[g] <= '0;
            end else if (ld_en && (ld_sel == SW'(g))) begin
                regs_q[g] <= ld_data;
            end
        end
    end

endmodule

// File: rtl/fmac_acc_bank.sv
module fmac_acc_bank #(
    parameter  int AW   = 56,
    parameter  int NACC = 2,
    localparam int SW   = (NACC > 1) ? $clog2(NACC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [SW-1:0] wsel,
    input  logic [AW-1:0] wdata,
    output logic [AW-1:0] acc_q [NACC]
);

    for (genvar g = 0; g < NACC; g++) begin : g_acc
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_q[g] <= '0;
            end else if (wen && (wsel == SW'(g))) begin
                acc_q[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/fmac_datapath.sv
module fmac_datapath
    import fmac_pkg::*;
#(
    parameter  int DW = 24,
    parameter  int EW = 8,
    localparam int AW = 2*DW + EW
) (
    input  op_e             op,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    input  logic [2*DW-1:0] pair,
    input  logic [AW-1:0]   acc_d,
    input  logic [AW-1:0]   acc_o,
    output logic [AW-1:0]   res
);

    localparam logic [AW-1:0] HALF = AW'(1) << (DW-1);
    localparam logic [DW-1:0] TIE  = {1'b1, {(DW-1){1'b0}}};

    logic signed [AW-1:0] ext_a;
    logic signed [AW-1:0] ext_b;
    logic signed [AW-1:0] mul;
    logic [AW-1:0]        prod;
    logic [AW-1:0]        mid_a;
    logic [AW-1:0]        ext_pair;
    logic [AW-1:0]        acc_plus;
    logic [AW-1:0]        acc_minus;

    // Convergent rounding at the boundary between the low and middle words.
    function automatic logic [AW-1:0] conv_round(input logic [AW-1:0] v);
        logic [AW-1:0] t;
        t = v + HALF;
        if (v[DW-1:0] == TIE) begin
            t[DW] = 1'b0;
        end
        t[DW-1:0] = '0;
        return t;
    endfunction

    assign ext_a     = {{(AW-DW){opa[DW-1]}}, opa};
    assign ext_b     = {{(AW-DW){opb[DW-1]}}, opb};
    assign mul       = ext_a * ext_b;
    assign prod      = {mul[AW-2:0], 1'b0};
    assign mid_a     = {ext_a[AW-1-DW:0], {DW{1'b0}}};
    assign ext_pair  = {{(AW-2*DW){pair[2*DW-1]}}, pair};
    assign acc_plus  = acc_d + prod;
    assign acc_minus = acc_d - prod;

    always_comb begin
        res = acc_d;
        unique case (op)
            OP_MPY:   res = prod;
            OP_MPYN:  res = '0 - prod;
            OP_MAC:   res = acc_plus;
            OP_MACN:  res = acc_minus;
            OP_MACR:  res = conv_round(acc_plus);
            OP_MACNR: res = conv_round(acc_minus);
            OP_RND:   res = conv_round(acc_d);
            OP_ADDX:  res = acc_d + mid_a;
            OP_SUBX:  res = acc_d - mid_a;
            OP_ADDL:  res = acc_d + ext_pair;
            OP_ADDA:  res = acc_d + acc_o;
            OP_SUBA:  res = acc_d - acc_o;
            OP_AND:   res[2*DW-1:DW] = acc_d[2*DW-1:DW] & opa;
            OP_OR:    res[2*DW-1:DW] = acc_d[2*DW-1:DW] | opa;
            OP_XOR:   res[2*DW-1:DW] = acc_d[2*DW-1:DW] ^ opa;
            OP_NOP:   res = acc_d;
        endcase
    end

endmodule

// File: rtl/frac_mac_unit.sv
module frac_mac_unit
    import fmac_pkg::*;
#(
    parameter  int DW = 24,
    parameter  int EW = 8,
    localparam int AW = 2*DW + EW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [1:0]    ld_sel,
    input  logic [DW-1:0] ld_data,
    input  logic          op_valid,
    input  logic [3:0]    op_code,
    input  logic [1:0]    op_src_a,
    input  logic [1:0]    op_src_b,
    input  logic          op_dst,
    output logic [AW-1:0] acc0_q,
    output logic [AW-1:0] acc1_q
);

    localparam int NREG = 4;
    localparam int NACC = 2;

    op_e             op;
    logic [DW-1:0]   regs_q [NREG];
    logic [AW-1:0]   acc_q  [NACC];
    logic [DW-1:0]   opa;
    logic [DW-1:0]   opb;
    logic [2*DW-1:0] pair;
    logic [1:0]      pair_lo;
    logic [1:0]      pair_hi;
    logic [AW-1:0]   result;

    assign op      = op_e'(op_code);
    assign opa     = regs_q[op_src_a];
    assign opb     = regs_q[op_src_b];
    assign pair_lo = {op_src_a[1], 1'b0};
    assign pair_hi = {op_src_a[1], 1'b1};
    assign pair    = {regs_q[pair_hi], regs_q[pair_lo]};

    fmac_operand_regs #(.DW(DW), .NREG(NREG)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_en   (ld_en),
        .ld_sel  (ld_sel),
        .ld_data (ld_data),
        .regs_q  (regs_q)
    );

    fmac_datapath #(.DW(DW), .EW(EW)) u_dp (
        .op    (op),
        .opa   (opa),
        .opb   (opb),
        .pair  (pair),
        .acc_d (acc_q[op_dst]),
        .acc_o (acc_q[~op_dst]),
        .res   (result)
    );

    fmac_acc_bank #(.AW(AW), .NACC(NACC)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .wen   (op_valid),
        .wsel  (op_dst),
        .wdata (result),
        .acc_q (acc_q)
    );

    assign acc0_q = acc_q[0];
    assign acc1_q = acc_q[1];

    for (genvar g = 0; g < NACC; g++) begin : g_chk
        // R9
        other_acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && (op_dst != 1'(g))) |=> $stable(acc_q[g]));

        // R9
        idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !op_valid |=> $stable(acc_q[g]));

        // R8
        logic_field_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && (op_dst == 1'(g)) && is_logic_op(op))
            |=> (acc_q[g][AW-1:2*DW] == $past(acc_q[g][AW-1:2*DW]))
                && (acc_q[g][DW-1:0] == $past(acc_q[g][DW-1:0])));

        // R5
        round_low_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (op_valid && (op_dst == 1'(g)) && is_round_op(op))
            |=> (acc_q[g][DW-1:0] == '0));
    end

endmodule

// File: tb/sim_frac_mac_unit.sv
`timescale 1ns/1ps
module sim_frac_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 1'b0;
    logic [1:0]  ld_sel = '0;
    logic [23:0] ld_data = '0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [1:0]  op_src_a = '0;
    logic [1:0]  op_src_b = '0;
    logic        op_dst = 1'b0;
    logic [55:0] acc0_q;
    logic [55:0] acc1_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [23:0] mreg [4];
    logic [55:0] macc [2];

    always #2.5 clk = ~clk;

    frac_mac_unit u0 (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .op_valid(op_valid), .op_code(op_code), .op_src_a(op_src_a), .op_src_b(op_src_b),
        .op_dst(op_dst), .acc0_q(acc0_q), .acc1_q(acc1_q)
    );

    function automatic logic [55:0] ref_round(input logic [55:0] v);
        logic [55:0] base;
        base = {v[55:24], 24'h0};
        if ((v[23:0] > 24'h800000) || ((v[23:0] == 24'h800000) && v[24]))
            base = base + 56'h1000000;
        return base;
    endfunction

    function automatic logic [55:0] ref_op(input logic [3:0] op, input logic [23:0] a,
        input logic [23:0] b, input logic [47:0] pr, input logic [55:0] d, input logic [55:0] o);
        longint sa, sb, sd, so, spr, p;
        logic [55:0] r;
        sa  = longint'($signed(a));
        sb  = longint'($signed(b));
        sd  = longint'($signed(d));
        so  = longint'($signed(o));
        spr = longint'($signed(pr));
        p   = sa * sb * 2;
        r   = d;
        case (op)
            4'h0: r = 56'(p);
            4'h1: r = 56'(-p);
            4'h2: r = 56'(sd + p);
            4'h3: r = 56'(sd - p);
            4'h4: r = ref_round(56'(sd + p));
            4'h5: r = ref_round(56'(sd - p));
            4'h6: r = ref_round(d);
            4'h7: r = 56'(sd + sa * 64'sd16777216);
            4'h8: r = 56'(sd - sa * 64'sd16777216);
            4'h9: r = 56'(sd + spr);
            4'hA: r = 56'(sd + so);
            4'hB: r = 56'(sd - so);
            4'hC: r[47:24] = d[47:24] & a;
            4'hD: r[47:24] = d[47:24] | a;
            4'hE: r[47:24] = d[47:24] ^ a;
            default: r = d;
        endcase
        return r;
    endfunction

    task automatic chk(input string req, input logic [55:0] act, input logic [55:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%014h expected=%014h", req, act, exp);
        end
    endtask

    // Called just after a falling edge; returns just after the next one.
    task automatic load(input int s, input logic [23:0] v);
        ld_en = 1'b1; ld_sel = 2'(s); ld_data = v;
        @(negedge clk);
        ld_en = 1'b0;
        mreg[s] = v;
    endtask

    task automatic run_op(input logic [3:0] op, input logic [1:0] a, input logic [1:0] b,
                          input logic d, input string req);
        logic [47:0] pr;
        logic [55:0] e;
        pr = a[1] ? {mreg[3], mreg[2]} : {mreg[1], mreg[0]};
        e = ref_op(op, mreg[a], mreg[b], pr, macc[d], macc[~d]);
        op_valid = 1'b1; op_code = op; op_src_a = a; op_src_b = b; op_dst = d;
        @(negedge clk);
        op_valid = 1'b0;
        macc[d] = e;
        chk(req, acc0_q, macc[0]);
        chk(req, acc1_q, macc[1]);
    endtask

    function automatic string req_of(input logic [3:0] op);
        case (op)
            4'h0, 4'h1: return "R3";
            4'h2, 4'h3: return "R4";
            4'h4, 4'h5, 4'h6: return "R5";
            4'h7, 4'h8: return "R6";
            4'h9, 4'hA, 4'hB: return "R7";
            default: return "R8";
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [23:0] vals [8];
        vals = '{24'h000000, 24'h000001, 24'h7FFFFF, 24'h800000,
                 24'h400000, 24'hFFFFFF, 24'h000003, 24'h123456};
        for (int i = 0; i < 4; i++) mreg[i] = '0;
        macc[0] = '0; macc[1] = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk("R1", acc0_q, 56'h0);
        chk("R1", acc1_q, 56'h0);
        load(0, 24'h7FFFFF);
        run_op(4'h0, 2'd1, 2'd2, 1'b0, "R1");  // registers 1 and 2 still zero

        // R2: load writes only the selected register
        load(2, 24'h00ABCD);
        run_op(4'h0, 2'd0, 2'd1, 1'b1, "R2");
        run_op(4'h7, 2'd2, 2'd0, 1'b1, "R2");
        chk("R2", acc1_q, 56'h00_00ABCD_000000);

        // R3: -1.0 * -1.0 lands in the guard bits without wrapping
        load(0, 24'h800000);
        load(1, 24'h800000);
        run_op(4'h0, 2'd0, 2'd1, 1'b0, "R3");
        chk("R3", acc0_q, 56'h00800000000000);
        run_op(4'h1, 2'd0, 2'd1, 1'b1, "R3");
        chk("R3", acc1_q, 56'hFF800000000000);

        // R4: repeated full-scale accumulation carries into the guard field
        load(0, 24'h7FFFFF);
        load(1, 24'h7FFFFF);
        run_op(4'h0, 2'd0, 2'd1, 1'b0, "R4");
        for (int k = 0; k < 4; k++) run_op(4'h2, 2'd0, 2'd1, 1'b0, "R4");
        chk("R4", {48'h0, acc0_q[55:48]}, 56'h2);
        for (int k = 0; k < 9; k++) run_op(4'h3, 2'd0, 2'd1, 1'b0, "R4");

        // R5: ties to even, ties from odd, and fused rounding
        load(0, 24'h400000);
        load(1, 24'h000001);
        load(2, 24'h000003);
        run_op(4'h0, 2'd0, 2'd1, 1'b0, "R5");
        run_op(4'h6, 2'd0, 2'd0, 1'b0, "R5");
        chk("R5", acc0_q, 56'h0);
        run_op(4'h0, 2'd0, 2'd2, 1'b0, "R5");
        run_op(4'h6, 2'd0, 2'd0, 1'b0, "R5");
        chk("R5", acc0_q, 56'h00000002000000);
        run_op(4'h4, 2'd0, 2'd2, 1'b0, "R5");
        run_op(4'h5, 2'd0, 2'd1, 1'b0, "R5");

        // R7: 48-bit pair and the other accumulator as sources
        load(3, 24'h800001);
        run_op(4'h9, 2'd2, 2'd0, 1'b1, "R7");
        run_op(4'hA, 2'd0, 2'd0, 1'b0, "R7");
        run_op(4'hB, 2'd0, 2'd0, 1'b1, "R7");

        // R9: idle cycles with other inputs toggling change nothing
        op_code = 4'h1; op_src_a = 2'd3; op_dst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", acc0_q, macc[0]);
        chk("R9", acc1_q, macc[1]);

        // Sweep: every code, both destinations, operand grid
        for (int op = 0; op < 16; op++) begin
            for (int d = 0; d < 2; d++) begin
                for (int i = 0; i < 8; i++) begin
                    for (int j = 0; j < 8; j++) begin
                        load(0, vals[i]);
                        load(1, vals[j]);
                        load(2, vals[(i + j) % 8] ^ 24'h5A5A5A);
                        load(3, ~vals[j]);
                        run_op(4'(op), 2'((i + op) % 4), 2'(j % 4), 1'(d), req_of(4'(op)));
                    end
                end
            end
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule